// File: doc/BRIEF.md
# Debug Core-to-Host Transmit Mailbox

This block carries one 64-bit word from a running processor core to an external debug host. The core stores the word as two 32-bit halves: the lower half first, then the upper half. Storing the lower half is optional. Storing the upper half is the step that marks the mailbox as full. The host learns that the mailbox is full in one of two ways: it polls the full flag, or it watches an event output that can be set to follow the flag.

The host then performs a serial read. A capture strobe copies the word into a shift register. The word then leaves on TDO, least significant bit first, one bit for each cycle in which the shift enable is high. An update strobe closes the read. If exactly 64 bits were shifted, the read is complete and the flag drops. A read of any other length leaves the flag set.

When the flag drops and the interrupt enable is set, a one-cycle debug interrupt request goes to the core, so that the core can store the next word. The test access port state machine is not part of this block. Its capture, shift and update strobes arrive as inputs that are already synchronous to `clk`.

Top module: `dbg_tx_mailbox`

## Requirements
- R1: After reset, `full`, `irq_pulse` and `evt_out` are 0.
- R2: A cycle with `wr_hi` high sets `full` to 1 from the next cycle on. The word later shifted out has the upper-half data in bits 63..32.
- R3: A cycle with `wr_lo` high and `wr_hi` low does not change `full`.
- R4: The lower half keeps its last stored value. If `wr_lo` is skipped, bits 31..0 of the shifted word are the previous lower half.
- R5: After `cap_strobe`, `tdo` presents bit 0 of the word. After k further cycles with `shift_en` high, it presents bit k. Bit order is least significant first.
- R6: An `upd_strobe` after exactly 64 shift cycles since the last capture clears `full` from the next cycle on.
- R7: An `upd_strobe` after any other number of shift cycles (for example 63 or 65) leaves `full` unchanged.
- R8: When `full` falls and `irq_en` is 1, `irq_pulse` is high for exactly one cycle, in the first cycle in which `full` reads 0. When `irq_en` is 0, `irq_pulse` stays 0.
- R9: `evt_out` equals `full` while `evt_en` is 1, and is 0 while `evt_en` is 0.
- R10: If `wr_hi` is high in the same cycle as a completing `upd_strobe`, `full` stays 1 and no interrupt pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the core side and the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Core stores `wr_data` as the lower half |
| wr_hi | input | 1 | Core stores `wr_data` as the upper half and sets the flag |
| wr_data | input | 32 | Half-word being stored |
| irq_en | input | 1 | Enables the interrupt when the flag drops |
| evt_en | input | 1 | Makes `evt_out` follow the flag |
| cap_strobe | input | 1 | Copies the stored word into the shift register |
| shift_en | input | 1 | Shifts one bit per cycle |
| upd_strobe | input | 1 | Ends the serial read |
| tdo | output | 1 | Serial data toward the host |
| full | output | 1 | Mailbox-full flag |
| evt_out | output | 1 | Event output toward the host |
| irq_pulse | output | 1 | One-cycle debug interrupt request to the core |

## Verification
The timing of each result is fixed:

- `full` changes one cycle after a `wr_hi` or a completing `upd_strobe`.
- `irq_pulse` rises in that same cycle, and is low again one cycle later.
- `tdo` is valid one cycle after `cap_strobe`, and then one cycle after each shift.
- `evt_out` follows `full` and `evt_en` combinationally.

All inputs change at the falling clock edge, and every output is sampled at the next falling edge, so each check falls exactly where its register has updated. The serial read is checked bit by bit over several computed word patterns. Reads of 63 and 65 bits check that an incomplete or overlong read leaves the flag set.

// File: rtl/dbg_tx_mailbox_pkg.sv
package dbg_tx_mailbox_pkg;
   localparam int unsigned WORD_W_DEF = 64;

   function automatic int unsigned cnt_bits(input int unsigned w);
      return $clog2(w + 2);
   endfunction
endpackage

// File: rtl/dbg_tx_stage.sv
module dbg_tx_stage #(
   parameter int unsigned WORD_W = 64,
   localparam int unsigned HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wr_data,
   output logic [WORD_W-1:0] word
);
   logic [HALF_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (wr_lo) lo_q <= wr_data;
         if (wr_hi) hi_q <= wr_data;
      end
   end

   assign word = {hi_q, lo_q};

   // R4: the lower half only changes when it is written
   a_r4_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> $stable(word[HALF_W-1:0]));
endmodule

// File: rtl/dbg_tx_shifter.sv
module dbg_tx_shifter #(
   parameter int unsigned WORD_W    = 64,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned CNT_W    = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              cap_strobe,
   input  logic              shift_en,
   output logic              tdo,
   output logic              done
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
         assign tdo     = sh_q[0];
      end else begin : g_msb
         assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
         assign tdo     = sh_q[WORD_W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= CNT_OVER;
      end else if (cap_strobe) begin
         sh_q  <= word;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= sh_next;
         if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == CNT_FULL);

   // R7: the counter saturates one past the word length
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_OVER);
   // R5: a capture restarts the bit count
   a_r5_cap_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |=> !done);
endmodule

// File: rtl/dbg_tx_flag.sv
module dbg_tx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hi,
   input  logic upd_strobe,
   input  logic done,
   input  logic irq_en,
   input  logic evt_en,
   output logic full,
   output logic evt_out,
   output logic irq_pulse
);
   logic full_q, full_d, irq_q;

   always_comb begin
      full_d = full_q;
      if (upd_strobe && done) full_d = 1'b0;
      if (wr_hi)              full_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         full_q <= full_d;
         irq_q  <= irq_en && full_q && !full_d;
      end
   end

   assign full      = full_q;
   assign irq_pulse = irq_q;
   assign evt_out   = evt_en && full_q;

   a_r2_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> full);
   a_r3_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi && !upd_strobe) |=> $stable(full));
   a_r7_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (full && upd_strobe && !done) |=> full);
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   a_r8_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (!full && $past(full) && $past(irq_en)));
   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && upd_strobe && done) |=> (full && !irq_pulse));
endmodule

// File: rtl/dbg_tx_mailbox.sv
module dbg_tx_mailbox #(
   parameter int unsigned WORD_W    = dbg_tx_mailbox_pkg::WORD_W_DEF,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned HALF_W   = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              irq_en,
   input  logic              evt_en,
   input  logic              cap_strobe,
   input  logic              shift_en,
   input  logic              upd_strobe,
   output logic              tdo,
   output logic              full,
   output logic              evt_out,
   output logic              irq_pulse
);
   initial begin
      if (WORD_W < 4 || (WORD_W % 2) != 0)
         $error("WORD_W must be even and at least 4");
   end

   logic [WORD_W-1:0] word;
   logic              done;

   dbg_tx_stage #(.WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .word(word));

   dbg_tx_shifter #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .word(word), .cap_strobe(cap_strobe),
      .shift_en(shift_en), .tdo(tdo), .done(done));

   dbg_tx_flag u_flag (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .upd_strobe(upd_strobe),
      .done(done), .irq_en(irq_en), .evt_en(evt_en), .full(full),
      .evt_out(evt_out), .irq_pulse(irq_pulse));

   // R9: the event output never shows a flag that is not set
   a_r9_evt_follow: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |-> full);
endmodule

// File: tb/dbg_tx_mailbox_bench.sv
module dbg_tx_mailbox_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_lo = 0, wr_hi = 0, irq_en = 0, evt_en = 0;
   logic cap_strobe = 0, shift_en = 0, upd_strobe = 0;
   logic [31:0] wr_data = '0;
   logic tdo, full, evt_out, irq_pulse;
   int checks = 0, errors = 0;
   int irq_seen;

   always #4 clk = ~clk;

   dbg_tx_mailbox u_dbg_tx_mailbox (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
      .irq_en(irq_en), .evt_en(evt_en), .cap_strobe(cap_strobe),
      .shift_en(shift_en), .upd_strobe(upd_strobe), .tdo(tdo), .full(full),
      .evt_out(evt_out), .irq_pulse(irq_pulse));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic put_lo(input logic [31:0] d);
      wr_lo = 1; wr_data = d; tick(); wr_lo = 0;
   endtask

   task automatic put_hi(input logic [31:0] d);
      wr_hi = 1; wr_data = d; tick(); wr_hi = 0;
   endtask

   // Capture, then shift n bits; bits seen on tdo are checked against exp.
   task automatic read_bits(input int n, input logic [63:0] exp);
      cap_strobe = 1; tick(); cap_strobe = 0;
      for (int k = 0; k < n; k++) begin
         if (k < 64) check("R5 tdo bit", 64'(tdo), 64'(exp[k]));
         shift_en = 1; tick();
      end
      shift_en = 0;
   endtask

   task automatic update();
      upd_strobe = 1; tick(); upd_strobe = 0;
   endtask

   initial begin
      #1_600_000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] w;
      logic [31:0] last_lo;
      tick(); tick();
      check("R1 full", 64'(full), 0);
      check("R1 irq", 64'(irq_pulse), 0);
      check("R1 evt", 64'(evt_out), 0);
      rst_n = 1; tick();
      check("R1 full after release", 64'(full), 0);

      // R3: lower half alone does not set the flag
      put_lo(32'h1234_5678);
      check("R3 lo only", 64'(full), 0);
      last_lo = 32'h1234_5678;

      // Sweep of word patterns through complete reads
      irq_en = 1; evt_en = 1;
      for (int p = 0; p < 6; p++) begin
         logic [31:0] lo, hi;
         lo = 32'h9E37_79B9 * (p + 1);
         hi = ~(32'h85EB_CA6B * (p + 3)) ^ (32'h1 << p);
         if (p % 2 == 0) begin put_lo(lo); last_lo = lo; end
         put_hi(hi);
         w = {hi, last_lo};
         check("R2 full set", 64'(full), 1);
         check("R9 evt follows", 64'(evt_out), 1);
         read_bits(64, w); // R4 on odd p: low half carried over
         check("R6 still full before update", 64'(full), 1);
         update();
         check("R6 cleared", 64'(full), 0);
         check("R8 pulse", 64'(irq_pulse), 1);
         check("R9 evt low", 64'(evt_out), 0);
         tick();
         check("R8 single", 64'(irq_pulse), 0);
      end

      // R7: aborted reads of 63 and 65 bits leave the flag set
      put_lo(32'hCAFE_0001); put_hi(32'hBEEF_0002);
      w = {32'hBEEF_0002, 32'hCAFE_0001};
      read_bits(63, w); update();
      check("R7 63 bits", 64'(full), 1);
      check("R7 no irq", 64'(irq_pulse), 0);
      read_bits(65, w); update();
      check("R7 65 bits", 64'(full), 1);
      check("R7 no irq 65", 64'(irq_pulse), 0);

      // R9: event masked
      evt_en = 0; #1;
      check("R9 evt masked", 64'(evt_out), 0);
      evt_en = 1;

      // R10: high write coincides with completing update
      read_bits(64, w);
      wr_hi = 1; wr_data = 32'h0BAD_F00D; upd_strobe = 1; tick();
      wr_hi = 0; upd_strobe = 0;
      check("R10 full kept", 64'(full), 1);
      check("R10 no irq", 64'(irq_pulse), 0);
      tick();
      check("R10 no irq later", 64'(irq_pulse), 0);

      // R8: interrupt disabled
      irq_en = 0;
      read_bits(64, {32'h0BAD_F00D, 32'hCAFE_0001});
      update();
      check("R8 cleared", 64'(full), 0);
      irq_seen = 0;
      for (int k = 0; k < 4; k++) begin
         if (irq_pulse) irq_seen++;
         tick();
      end
      check("R8 no pulse when disabled", 64'(irq_seen), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule